// File: doc/BRIEF.md
# DCC Bit Waveform Serializer

This block turns a stream of message bytes into the square-wave track signal used by digital model-railway control. Every bit becomes one full symmetric cycle. The output is high for the first half and low for the second half. The length of the cycle depends on the bit value: a one gives a short cycle and a zero gives a long one. Bytes are sent least significant bit first.

Bytes arrive on a valid/ready stream. Back-pressure works as follows:
- `in_ready` is high exactly when the one-byte holding register is empty.
- A byte is taken on any clock where `in_valid` and `in_ready` are both high.
- While the holding register is full, `in_ready` stays low and the upstream side must keep its byte stable.

The held byte lets the next byte queue up while the current one is on the wire.

Timing is built from a clock-enable tick of one microsecond. An up-counter inside the block advances on that tick. It wraps at the end of every bit cycle, and it loads the compare value for the next bit only at that wrap. When no byte is waiting at the end of a byte, the line goes low and idles until a new byte arrives.

Top module: `dcc_wave_tx`

## Requirements
- R1: After a synchronous active-high reset, `wave_out`, `busy` and `byte_done` are 0 and `in_ready` is 1.
- R2: A bit of value 1 drives `wave_out` high for HALF_ONE×CLK_PER_US clocks, then low for the same number of clocks.
- R3: A bit of value 0 drives `wave_out` high for HALF_ZERO×CLK_PER_US clocks, then low for the same number of clocks.
- R4: The bits of a byte go out in order from bit 0 up to bit 7.
- R5: A bit's period is fixed at the cycle boundary. `wave_out` rises only when the internal cycle counter is at zero, and it falls only when that counter equals the current bit's half count.
- R6: `in_ready` equals "holding register empty". A byte accepted while another byte is being sent makes `in_ready` low until that byte is taken for transmission.
- R7: When a byte is waiting at the end of bit 7, its bit 0 starts on the next clock with no idle gap, and `busy` stays high.
- R8: When no byte is available at the end of bit 7, `wave_out` and `busy` are low from the next clock. A later accepted byte starts a fresh cycle, so `wave_out` is high on the clock after the handshake.
- R9: `byte_done` is high for exactly one clock: the clock right after the low half of bit 7 ends.
- R10: A byte accepted in the very clock in which bit 7 ends is used at once. Its first cycle follows with no idle clock.
- R11: The cycle counter never exceeds twice the larger half count minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can accept a byte (holding register empty) |
| in_data | input | 8 | Message byte |
| wave_out | output | 1 | Track waveform |
| busy | output | 1 | A byte is being sent |
| byte_done | output | 1 | One-clock strobe after bit 7 finishes |

## Verification
Two functions can fall in the same clock: the end of bit 7, and the handshake of the next byte. When both happen together, the incoming byte goes directly into the shift path and does not pass through the holding register.

The bench provokes this in two ways. First, it raises `in_valid` exactly in the last clock of a byte. Second, it raises it one clock later. In the first case the bench expects the next rising edge with no gap and `busy` held high. In the second case it expects one idle low clock, followed by a fresh cycle. In both cases `byte_done` must pulse exactly once, and the following half-period lengths are checked clock by clock.

// File: rtl/dcc_wave_pkg.sv
package dcc_wave_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dcc_tick_gen.sv
module dcc_tick_gen #(
  parameter int unsigned CLK_PER_US = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div;

  assign tick = run && (div == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) div <= '0;
    else if (div == LAST) div <= '0;
    else div <= div + 1'b1;
  end

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dcc_period_ctr.sv
module dcc_period_ctr #(
  parameter int unsigned HALF_ONE  = 58,
  parameter int unsigned HALF_ZERO = 100,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic          bit_val,
  output logic [CW-1:0] cnt,
  output logic          mid,
  output logic          wrap
);
  localparam logic [CW-1:0] MID1  = CW'(HALF_ONE - 1);
  localparam logic [CW-1:0] MID0  = CW'(HALF_ZERO - 1);
  localparam logic [CW-1:0] TERM1 = CW'(2 * HALF_ONE - 1);
  localparam logic [CW-1:0] TERM0 = CW'(2 * HALF_ZERO - 1);
  localparam logic [CW-1:0] TOP   = CW'(2 * dcc_wave_pkg::larger(HALF_ONE, HALF_ZERO) - 1);

  logic [CW-1:0] term_sel;
  logic [CW-1:0] mid_sel;

  always_comb begin
    term_sel = bit_val ? TERM1 : TERM0;
    mid_sel  = bit_val ? MID1  : MID0;
  end

  assign mid  = tick && (cnt == mid_sel);
  assign wrap = tick && (cnt == term_sel);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
endmodule

// File: rtl/dcc_bit_seq.sv
module dcc_bit_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       mid,
  input  logic       wrap,
  output logic       start,
  output logic       busy,
  output logic       wave,
  output logic       done,
  output logic       cur_bit
);
  import dcc_wave_pkg::*;

  tx_state_e  state;
  logic [7:0] hold;
  logic       hold_full;
  logic [7:0] shreg;
  logic [2:0] idx;
  logic       accept;
  logic       avail;
  logic [7:0] next_byte;
  logic       last_end;
  logic       consume;

  assign in_ready  = !hold_full;
  assign accept    = in_valid && in_ready;
  assign avail     = hold_full || accept;
  assign next_byte = hold_full ? hold : in_data;
  assign start     = (state == ST_IDLE) && avail;
  assign last_end  = (state == ST_SEND) && wrap && (idx == 3'd7);
  assign consume   = start || (last_end && avail);
  assign busy      = (state == ST_SEND);
  assign cur_bit   = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (consume) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold      <= in_data;
      hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      shreg <= '0;
      idx   <= '0;
      wave  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (avail) begin
            state <= ST_SEND;
            shreg <= next_byte;
            idx   <= '0;
            wave  <= 1'b1;
          end
        end
        default: begin
          if (wrap) begin
            if (idx != 3'd7) begin
              idx   <= idx + 3'd1;
              shreg <= {1'b0, shreg[7:1]};
              wave  <= 1'b1;
            end else begin
              done <= 1'b1;
              idx  <= '0;
              if (avail) begin
                shreg <= next_byte;
                wave  <= 1'b1;
              end else begin
                state <= ST_IDLE;
                wave  <= 1'b0;
              end
            end
          end else if (mid) begin
            wave <= 1'b0;
          end
        end
      endcase
    end
  end

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !consume) |=> (hold_full && $stable(hold)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wave);
endmodule

// File: rtl/dcc_wave_tx.sv
module dcc_wave_tx #(
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned HALF_ONE   = 58,
  parameter int unsigned HALF_ZERO  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       wave_out,
  output logic       busy,
  output logic       byte_done
);
  localparam int unsigned MAXH = dcc_wave_pkg::larger(HALF_ONE, HALF_ZERO);
  localparam int unsigned CW   = $clog2(2 * MAXH);

  logic          tick;
  logic          start;
  logic          mid;
  logic          wrap;
  logic          cur_bit;
  logic [CW-1:0] cnt;

  dcc_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (tick)
  );

  dcc_period_ctr #(.HALF_ONE(HALF_ONE), .HALF_ZERO(HALF_ZERO), .CW(CW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .tick    (tick),
    .bit_val (cur_bit),
    .cnt     (cnt),
    .mid     (mid),
    .wrap    (wrap)
  );

  dcc_bit_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .mid      (mid),
    .wrap     (wrap),
    .start    (start),
    .busy     (busy),
    .wave     (wave_out),
    .done     (byte_done),
    .cur_bit  (cur_bit)
  );

  // R5
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wave_out) |-> (cnt == '0));

  // R5
  fall_at_half_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wave_out) |-> (cnt == (cur_bit ? CW'(HALF_ONE) : CW'(HALF_ZERO))));
endmodule

// File: tb/dcc_wave_tx_bench.sv
module dcc_wave_tx_bench;
  localparam int C  = 2;
  localparam int H1 = 3;
  localparam int H0 = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, wave_out, busy, byte_done;

  int vectors = 0;
  int misses  = 0;
  logic [7:0] stim [0:255];

  always #5 clk = ~clk;

  dcc_wave_tx #(.CLK_PER_US(C), .HALF_ONE(H1), .HALF_ZERO(H0)) u_dcc_wave_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wave_out(wave_out), .busy(busy), .byte_done(byte_done)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Checks wave/busy/done clock by clock for n bytes from stim, starting at sample 0.
  task automatic expect_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        int h;
        h = stim[i][j] ? H1 * C : H0 * C;
        for (int k = 0; k < 2 * h; k++) begin
          chk(wave_out, (k < h), stim[i][j] ? "R2/R4 wave bit1" : "R3/R4 wave bit0");
          chk(busy, 1'b1, "R7 busy during stream");
          chk(byte_done, (i > 0 && j == 0 && k == 0), "R9 done strobe");
          @(negedge clk);
        end
      end
    end
    chk(wave_out, 1'b0, "R8 wave low after last byte");
    chk(busy, 1'b0, "R8 busy low after last byte");
    chk(byte_done, 1'b1, "R9 done after last byte");
    @(negedge clk);
    chk(byte_done, 1'b0, "R9 done single clock");
  endtask

  task automatic drive_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      logic r;
      in_valid = 1'b1;
      in_data  = stim[i];
      do begin
        r = in_ready;
        @(negedge clk);
      end while (!r);
      if (i > 0) chk(in_ready, 1'b0, "R6 ready low while holding");
    end
    in_valid = 1'b0;
    in_data  = 8'hA5;
  endtask

  task automatic run_stream(input int n);
    fork
      drive_bytes(n);
      begin
        @(negedge clk);
        expect_bytes(n);
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(wave_out, 1'b0, "R1 reset wave");
    chk(busy, 1'b0, "R1 reset busy");
    chk(byte_done, 1'b0, "R1 reset done");
    chk(in_ready, 1'b1, "R1 reset ready");

    // single byte, mixed bits
    stim[0] = 8'b1001_1011;
    run_stream(1);

    // exhaustive back-to-back stream of every byte value (R2 R3 R4 R6 R7)
    for (int v = 0; v < 256; v++) stim[v] = 8'(v);
    run_stream(256);

    // idle gap then restart with fresh cycle (R8)
    repeat (5) begin
      chk(wave_out, 1'b0, "R8 idle wave");
      @(negedge clk);
    end
    stim[0] = 8'h00;
    run_stream(1);

    // R10: next byte handshake coincides with end of bit 7
    in_valid = 1'b1; in_data = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready, 1'b1, "R6 ready after direct load");
    repeat (95) @(negedge clk);
    in_valid = 1'b1; in_data = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    chk(wave_out, 1'b1, "R10 no gap wave");
    chk(busy, 1'b1, "R10 busy held");
    chk(byte_done, 1'b1, "R10 done");
    chk(in_ready, 1'b1, "R10 bypass leaves hold empty");
    repeat (9) @(negedge clk);
    chk(wave_out, 1'b1, "R10 zero bit high end");
    @(negedge clk);
    chk(wave_out, 1'b0, "R10 zero bit low start");
    repeat (160) @(negedge clk);
    chk(busy, 1'b0, "R8 idle after R10 byte");

    // one clock late: idle clock then fresh cycle (R8)
    in_valid = 1'b1; in_data = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (96) @(negedge clk);
    chk(wave_out, 1'b0, "R8 late wave low");
    chk(busy, 1'b0, "R8 late busy low");
    chk(byte_done, 1'b1, "R9 late done");
    in_valid = 1'b1; in_data = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    chk(wave_out, 1'b1, "R8 fresh cycle high");
    chk(busy, 1'b1, "R8 fresh busy");
    chk(byte_done, 1'b0, "R9 no repeat done");
    repeat (9) @(negedge clk);
    chk(wave_out, 1'b1, "R3 fresh high end");
    @(negedge clk);
    chk(wave_out, 1'b0, "R3 fresh low start");
    repeat (160) @(negedge clk);
    chk(busy, 1'b0, "R8 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule